// File: doc/BRIEF.md
# Configurable Trigger Interrupt Controller

This block collects up to 32 interrupt sources and turns them into two request lines and one wake line. Software writes a three-bit trigger code for each source, held across three bit-planes, and chooses one of five trigger kinds: rising edge, falling edge, both edges, high level or low level. Each source also has a mask bit, a wake-enable bit, a source-select bit that picks between two input vectors, and a routing bit that sends it to one of the two request outputs.

Every control plane has a set address and a clear address. A write of 1 to a bit sets or clears that bit, and a write of 0 leaves it as it was, so one source can be changed without a read-modify-write. Edge events are caught in separate rising and falling latches. Each latch is cleared through its own write-only address. All control state and both pending words can be read back through a separate read port, so software can save and restore the configuration. To cover 64 sources, two instances are placed side by side outside the block.

Top module: `trig_intc`

## Requirements
- R1: Planes are addressed on the write port as set = 2p and clear = 2p+1, with p = 0 cfg0, 1 cfg1, 2 cfg2, 3 mask, 4 wake, 5 source select, 6 assign. A 1 in the write data sets or clears the matching bit. A 0 leaves that bit unchanged. Plane p reads back at read address p, and the new value is visible from the cycle after the write.
- R2: After reset, cfg0, cfg1, cfg2, mask, wake, both edge latches and the test word read 0. Source select and assign read all ones.
- R3: The trigger code is {cfg2,cfg1,cfg0}. 001 latches rising edges, 010 latches falling edges and 011 latches both. A changed input shows on the outputs within four clock edges, after a two-flop synchronizer and one latch stage.
- R4: Code 101 requests while the synchronized input is 1, and code 110 requests while it is 0. Codes 000, 100 and 111 never request.
- R5: An edge latch stays set after the input returns to its idle level. Writing 1 to address 14 clears the rising latch and writing 1 to address 15 clears the falling latch. In both-edge mode a source with both latches set stays pending until both latches are cleared. The latches read back at addresses 9 (rising) and 10 (falling).
- R6: A source requests only while its mask bit is 1. Clearing the mask removes a level request in the cycle after the write.
- R7: A pending source with assign bit 1 drives irq_req0 and appears in pend_req0 and at read address 7. With assign bit 0 it drives irq_req1 and appears in pend_req1 and at read address 8.
- R8: irq_wake is the OR of the pending sources whose wake bit is 1.
- R9: The test word is written at address 16 and read at address 11. While it is nonzero, irq_req0, irq_req1 and irq_wake are held low. Writing 0 returns the block to normal operation.
- R10: When a source's select bit is 1 it samples src_main, and when it is 0 it samples src_alt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data, one bit per source |
| rd_addr | input | 5 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| src_main | input | 32 | Main interrupt inputs, asynchronous |
| src_alt | input | 32 | Alternate interrupt inputs, asynchronous |
| irq_req0 | output | 1 | Request output 0 |
| irq_req1 | output | 1 | Request output 1 |
| irq_wake | output | 1 | Wake output |
| pend_req0 | output | 32 | Sources pending on request 0 |
| pend_req1 | output | 32 | Sources pending on request 1 |

## Verification
The bench runs every trigger code against rising and falling input transitions, including the unused codes 100 and 111. A decoder that reads only one plane would treat 101 as a rising edge or 100 as a level. It checks that a short pulse stays latched, and that a both-edge source with both latches set survives a clear of only one latch. A design that shared one latch would drop that source early. It also flips the assign bit, the source-select bit and the test word, and writes zero data to set and clear addresses. Swapped routing, a swapped input select, a missing output gate or a write that forces whole words would each show up at the request pins or in the read-back.

// File: rtl/tic_pkg.sv
package tic_pkg;
   localparam int ADDR_W    = 5;
   localparam int N_PLANES  = 7;
   // plane indices
   localparam int PL_CFG0   = 0;
   localparam int PL_CFG1   = 1;
   localparam int PL_CFG2   = 2;
   localparam int PL_MASK   = 3;
   localparam int PL_WAKE   = 4;
   localparam int PL_SRC    = 5;
   localparam int PL_ASGN   = 6;
   // write-only addresses beyond the plane pairs
   localparam logic [ADDR_W-1:0] WA_RISE_CLR = 5'd14;
   localparam logic [ADDR_W-1:0] WA_FALL_CLR = 5'd15;
   localparam logic [ADDR_W-1:0] WA_TEST     = 5'd16;
   // read addresses beyond the planes
   localparam logic [ADDR_W-1:0] RA_PEND0    = 5'd7;
   localparam logic [ADDR_W-1:0] RA_PEND1    = 5'd8;
   localparam logic [ADDR_W-1:0] RA_RISE     = 5'd9;
   localparam logic [ADDR_W-1:0] RA_FALL     = 5'd10;
   localparam logic [ADDR_W-1:0] RA_TEST     = 5'd11;

   function automatic logic plane_rst_ones(int p);
      return (p == PL_SRC) || (p == PL_ASGN);
   endfunction
endpackage

// File: rtl/tic_sync.sv
module tic_sync #(
   parameter int N      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   initial begin
      if (STAGES < 2) $error("tic_sync: STAGES must be at least 2");
   end

   logic [N-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tic_setclr.sv
module tic_setclr #(
   parameter int   W        = 32,
   parameter logic RST_ONES = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_stb,
   input  logic         clr_stb,
   input  logic [W-1:0] data,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= {W{RST_ONES}};
      else q <= (q | (set_stb ? data : '0)) & ~(clr_stb ? data : '0);
   end

   assert_set_hits_R1: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb |=> ((q & $past(data)) == $past(data)));
   assert_clr_hits_R1: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb |=> ((q & $past(data)) == '0));
   assert_zero_keeps_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (set_stb || clr_stb) |=> ((q & ~$past(data)) == ($past(q) & ~$past(data))));
endmodule

// File: rtl/tic_detect.sv
module tic_detect #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] in_s,
   input  logic [N-1:0] c0,
   input  logic [N-1:0] c1,
   input  logic [N-1:0] c2,
   input  logic [N-1:0] mask,
   input  logic [N-1:0] rise_clr,
   input  logic [N-1:0] fall_clr,
   output logic [N-1:0] pend,
   output logic [N-1:0] rise_lat,
   output logic [N-1:0] fall_lat
);
   logic [N-1:0] prev;
   logic [N-1:0] rise_en, fall_en, hi_en, lo_en;
   logic [N-1:0] rise_hit, fall_hit;

   // trigger code {c2,c1,c0}: 001 rise, 010 fall, 011 both, 101 high, 110 low
   assign rise_en  = ~c2 & c0;
   assign fall_en  = ~c2 & c1;
   assign hi_en    = c2 & ~c1 & c0;
   assign lo_en    = c2 & c1 & ~c0;
   assign rise_hit = in_s & ~prev & rise_en;
   assign fall_hit = ~in_s & prev & fall_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev     <= '0;
         rise_lat <= '0;
         fall_lat <= '0;
      end else begin
         prev     <= in_s;
         rise_lat <= (rise_lat & ~rise_clr) | rise_hit;
         fall_lat <= (fall_lat & ~fall_clr) | fall_hit;
      end
   end

   assign pend = mask & ((rise_lat & rise_en) | (fall_lat & fall_en) |
                         (in_s & hi_en) | (~in_s & lo_en));

   assert_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((rise_lat & ~$past(rise_lat)) & ~$past(in_s & ~prev)) == '0);
   assert_fall_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((fall_lat & ~$past(fall_lat)) & ~$past(~in_s & prev)) == '0);
endmodule

// File: rtl/trig_intc.sv
module trig_intc
   import tic_pkg::*;
#(
   parameter int N_SRC       = 32,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [N_SRC-1:0]  src_main,
   input  logic [N_SRC-1:0]  src_alt,
   output logic              irq_req0,
   output logic              irq_req1,
   output logic              irq_wake,
   output logic [N_SRC-1:0]  pend_req0,
   output logic [N_SRC-1:0]  pend_req1
);
   localparam int PAD = DATA_W - N_SRC;

   initial begin
      if (N_SRC > DATA_W) $error("trig_intc: N_SRC exceeds DATA_W");
      if (N_SRC < 1) $error("trig_intc: N_SRC must be positive");
   end

   logic [N_SRC-1:0]  plane [N_PLANES];
   logic [N_SRC-1:0]  wbits;
   logic [N_SRC-1:0]  in_raw, in_s, pend, rise_lat, fall_lat, rise_clr, fall_clr;
   logic [DATA_W-1:0] test_q;
   logic              normal;

   assign wbits = wr_data[N_SRC-1:0];

   genvar p;
   generate
      for (p = 0; p < N_PLANES; p++) begin : g_plane
         tic_setclr #(.W(N_SRC), .RST_ONES(plane_rst_ones(p))) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (wr_en && (wr_addr == ADDR_W'(2*p))),
            .clr_stb (wr_en && (wr_addr == ADDR_W'(2*p+1))),
            .data    (wbits),
            .q       (plane[p])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) test_q <= '0;
      else if (wr_en && wr_addr == WA_TEST) test_q <= wr_data;
   end

   assign rise_clr = (wr_en && wr_addr == WA_RISE_CLR) ? wbits : '0;
   assign fall_clr = (wr_en && wr_addr == WA_FALL_CLR) ? wbits : '0;

   assign in_raw = (plane[PL_SRC] & src_main) | (~plane[PL_SRC] & src_alt);

   tic_sync #(.N(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (rst_n), .d (in_raw), .q (in_s)
   );

   tic_detect #(.N(N_SRC)) u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_s     (in_s),
      .c0       (plane[PL_CFG0]),
      .c1       (plane[PL_CFG1]),
      .c2       (plane[PL_CFG2]),
      .mask     (plane[PL_MASK]),
      .rise_clr (rise_clr),
      .fall_clr (fall_clr),
      .pend     (pend),
      .rise_lat (rise_lat),
      .fall_lat (fall_lat)
   );

   assign pend_req0 = pend & plane[PL_ASGN];
   assign pend_req1 = pend & ~plane[PL_ASGN];
   assign normal    = (test_q == '0);
   assign irq_req0  = normal && (|pend_req0);
   assign irq_req1  = normal && (|pend_req1);
   assign irq_wake  = normal && (|(pend & plane[PL_WAKE]));

   function automatic logic [DATA_W-1:0] widen(logic [N_SRC-1:0] v);
      return {{PAD{1'b0}}, v};
   endfunction

   always_comb begin
      rd_data = '0;
      if (rd_addr < ADDR_W'(N_PLANES)) rd_data = widen(plane[rd_addr[2:0]]);
      else begin
         case (rd_addr)
            RA_PEND0: rd_data = widen(pend_req0);
            RA_PEND1: rd_data = widen(pend_req1);
            RA_RISE:  rd_data = widen(rise_lat);
            RA_FALL:  rd_data = widen(fall_lat);
            RA_TEST:  rd_data = test_q;
            default:  rd_data = '0;
         endcase
      end
   end

   assert_wake_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_wake |-> (irq_req0 || irq_req1));
   assert_test_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req0 || irq_req1 || irq_wake) |-> (test_q == '0));
   assert_mask_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(2*PL_MASK+1)) |=> ((pend & $past(wbits)) == '0));
   assert_route_disjoint_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_req0 & pend_req1) == '0);
endmodule

// File: tb/test_trig_intc.sv
module test_trig_intc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [4:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [31:0] src_main = '0;
   logic [31:0] src_alt = '0;
   logic        irq_req0, irq_req1, irq_wake;
   logic [31:0] pend_req0, pend_req1;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   trig_intc i_trig_intc (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
      .src_main (src_main), .src_alt (src_alt), .irq_req0 (irq_req0),
      .irq_req1 (irq_req1), .irq_wake (irq_wake),
      .pend_req0 (pend_req0), .pend_req1 (pend_req1)
   );

   localparam logic [31:0] B = 32'h0000_0020;  // source 5

   // {mode[2:0], assign, mask, wake, before, after, exp_req0, exp_req1, exp_wake}
   localparam int NV = 16;
   localparam logic [10:0] VEC [NV] = '{
      {3'b001,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0},  // R3 rise
      {3'b001,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0},  // R3 rise, falling input
      {3'b010,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0},  // R3 fall to req1
      {3'b010,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0},  // R3 fall, rising input
      {3'b011,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0},  // R3 both, rise
      {3'b011,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1},  // R3 both, fall, wake R8
      {3'b101,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1},  // R4 high
      {3'b101,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0},  // R4 high, idle
      {3'b110,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0},  // R4 low
      {3'b110,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0},  // R4 low, idle
      {3'b001,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0},  // R6 masked
      {3'b000,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0},  // R4 code 000
      {3'b100,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0},  // R4 code 100
      {3'b111,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0},  // R4 code 111
      {3'b101,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0},  // R7 level to req1
      {3'b110,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1}   // R8 low with wake
   };

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic set_mode(input logic [2:0] m);
      wr(5'd1, B); wr(5'd3, B); wr(5'd5, B);
      if (m[0]) wr(5'd0, B);
      if (m[1]) wr(5'd2, B);
      if (m[2]) wr(5'd4, B);
   endtask

   task automatic put_bit(input int plane, input logic v);
      wr(5'(2*plane + (v ? 0 : 1)), B);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++; n_vec++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] r;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R2 reset state
      for (int a = 0; a < 7; a++) begin
         rd(5'(a), r);
         chk("R2 plane reset", r, (a == 5 || a == 6) ? 32'hFFFF_FFFF : 32'h0);
      end
      rd(5'd9, r);  chk("R2 rise latch reset", r, 32'h0);
      rd(5'd10, r); chk("R2 fall latch reset", r, 32'h0);
      rd(5'd11, r); chk("R2 test reset", r, 32'h0);
      chk("R2 outputs reset", {29'h0, irq_req0, irq_req1, irq_wake}, 32'h0);

      // R1 set/clear with zero bits untouched
      wr(5'd6, 32'h0000_0003);
      wr(5'd6, 32'h0000_0100);
      rd(5'd3, r); chk("R1 mask set accumulates", r, 32'h0000_0103);
      wr(5'd7, 32'h0000_0001);
      rd(5'd3, r); chk("R1 mask clear one bit", r, 32'h0000_0102);
      wr(5'd13, 32'h0000_0F00);
      rd(5'd6, r); chk("R1 assign clear", r, 32'hFFFF_F0FF);
      wr(5'd12, 32'h0000_0F00);
      wr(5'd7, 32'hFFFF_FFFF);
      rd(5'd3, r); chk("R1 mask clear all", r, 32'h0);

      // table walk, source 5
      for (int v = 0; v < NV; v++) begin
         logic [10:0] e;
         e = VEC[v];
         set_mode(e[10:8]);
         put_bit(6, e[7]);
         put_bit(3, e[6]);
         put_bit(4, e[5]);
         src_main = e[4] ? B : 32'h0;
         idle(6);
         wr(5'd14, B); wr(5'd15, B);
         src_main = e[3] ? B : 32'h0;
         idle(6);
         chk($sformatf("R3/R4/R7/R8 vector %0d outputs", v),
             {29'h0, irq_req0, irq_req1, irq_wake}, {29'h0, e[2:0]});
      end

      // R5 pulse stays latched, both-edge needs both clears
      set_mode(3'b011); put_bit(6, 1'b1); put_bit(3, 1'b1); put_bit(4, 1'b0);
      src_main = 32'h0; idle(6);
      wr(5'd14, B); wr(5'd15, B);
      src_main = B; idle(6); src_main = 32'h0; idle(6);
      chk("R5 pulse latched", {31'h0, irq_req0}, 32'h1);
      rd(5'd9, r);  chk("R5 rise latch readback", r, B);
      rd(5'd10, r); chk("R5 fall latch readback", r, B);
      rd(5'd7, r);  chk("R7 pending word 0", r, B);
      rd(5'd8, r);  chk("R7 pending word 1 empty", r, 32'h0);
      wr(5'd14, B); idle(1);
      chk("R5 one clear keeps pending", {31'h0, irq_req0}, 32'h1);
      wr(5'd15, B); idle(1);
      chk("R5 both clears drop pending", {31'h0, irq_req0}, 32'h0);

      // R6 level drop in cycle after mask clear
      set_mode(3'b101); src_main = B; idle(6);
      chk("R6 level pending", {31'h0, irq_req0}, 32'h1);
      wr(5'd7, B);
      chk("R6 mask clear drops", {31'h0, irq_req0}, 32'h0);
      wr(5'd6, B);

      // R9 test word gates outputs
      wr(5'd16, 32'h0000_0001);
      chk("R9 test gates req0", {31'h0, irq_req0}, 32'h0);
      rd(5'd11, r); chk("R9 test readback", r, 32'h1);
      wr(5'd16, 32'h0);
      chk("R9 normal after zero", {31'h0, irq_req0}, 32'h1);

      // R10 source select
      src_main = 32'h0; src_alt = B; idle(6);
      chk("R10 main selected", {31'h0, irq_req0}, 32'h0);
      wr(5'd11, B); idle(6);
      chk("R10 alt selected", {31'h0, irq_req0}, 32'h1);
      rd(5'd5, r); chk("R10 select readback", r, ~B);
      wr(5'd10, B); idle(6);
      chk("R10 back to main", {31'h0, irq_req0}, 32'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule